// File: doc/BRIEF.md
# Serial Transmit Unit with Byte Queue

This block is the sending side of a register-mapped asynchronous serial port. Bytes offered on a small write stream are held in a 32-entry queue. A shift engine takes them one at a time and drives them onto a single line. The bit rate comes from the core clock: a programmable divisor sets an oversampling tick, and sixteen such ticks make one bit.

Each frame has a low start bit, eight data bits sent lowest first, an optional even parity bit, and one or two high stop bits. A break control forces the line low. A flush pulse discards whatever is still queued. The surrounding register block reads five status flags covering the queue and the shifter. The write port follows valid/ready rules. A byte transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` falls when the queue is full or a flush is in progress. A byte offered while `wr_ready` is low is not taken, and the source may hold it or drop it.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset `tx_line` is 1, `st_fifo_empty`, `st_tx_empty` and `wr_ready` are 1, and `st_fifo_full` and `st_fifo_half` are 0.
- R2: A frame is one 0 start bit, then data bits 0 through 7 in that order, then stop bits at 1. Between frames the line rests at 1.
- R3: Every bit lasts 16 × `baud_div` clock cycles, for divisor values 2 to 1023. When the queue still holds data, the next start bit begins exactly one frame length after the previous one.
- R4: With `par_en` = 1, a parity bit equal to the XOR of the eight data bits follows bit 7, so the count of ones is even. With `par_en` = 0, no parity bit is sent.
- R5: With `two_stop` = 1 a frame ends with two stop bits (12 bits with parity, 11 without). With `two_stop` = 0 it ends with one stop bit.
- R6: While `brk_en` is 1, `tx_line` is 0 and no new frame starts, so queued bytes stay queued. After `brk_en` returns to 0, the queued bytes go out as normal frames.
- R7: While `flush` is 1, the queue empties by the next clock edge and `wr_ready` is 0. Bytes discarded this way are never sent.
- R8: The queue holds 32 bytes and sends them in write order. `st_fifo_full` is 1 at 32 entries. A byte offered while full is not taken and leaves the queue unchanged.
- R9: `st_fifo_half` is 1 when the queue holds 16 or more entries and 0 when it holds 15 or fewer.
- R10: `st_tx_empty` is 1 only when the queue is empty and the last stop bit has finished. `st_tx_ready` is 1 whenever the queue has room for another byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write stream: byte offered |
| wr_data | input | 8 | Write stream: byte value |
| wr_ready | output | 1 | Write stream: queue accepts this cycle |
| baud_div | input | 10 | Clocks per oversampling tick (2..1023) |
| par_en | input | 1 | Append even parity bit |
| two_stop | input | 1 | Append a second stop bit |
| brk_en | input | 1 | Hold line low, stall new frames |
| flush | input | 1 | Empty the queue |
| tx_line | output | 1 | Serial output, idle high |
| st_fifo_empty | output | 1 | Queue holds no bytes |
| st_fifo_full | output | 1 | Queue holds 32 bytes |
| st_fifo_half | output | 1 | Queue holds at least 16 bytes |
| st_tx_empty | output | 1 | Queue empty and shifter finished |
| st_tx_ready | output | 1 | Queue has room |

## Verification
The in-line properties watch, on every cycle, the invariants that span the queue and the shifter. The queue never exceeds its depth and a full queue ignores writes. A flush clears the queue. A frame starts only when data is present and break is off. The line stays high whenever the shifter is idle and not in break. Bit timing, parity values, stop-bit counts and write ordering depend on whole frames, so only the bench scenarios can show them. The bench sweeps several divisors across all four parity and stop-bit settings, and it decodes every frame against arithmetic expectations.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // oversampling ticks per serial bit
  localparam int SER_OSR = 16;

  // per-frame options latched when a byte leaves the queue
  typedef struct packed {
    logic par_en;
    logic two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         half
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_LVL = (AW+1)'(DEPTH / 2);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  wire do_push = push && !full && !flush;
  wire do_pop  = pop && !empty && !flush;

  assign empty = (cnt == '0);
  assign full  = (cnt == FULL_LVL);
  assign half  = (cnt >= HALF_LVL);
  assign dout  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  // R8
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_LVL);
  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> $stable(cnt));
  // R7
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  // R9
  half_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> half);
endmodule

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 10,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             bit_done
);
  localparam int SW = $clog2(OSR);
  localparam logic [SW-1:0] SUB_LAST = SW'(OSR - 1);

  logic [DIV_W-1:0] os_cnt;
  logic [SW-1:0]    sub;

  // >= keeps a shrinking divisor from stretching one tick to a full wrap
  wire os_tick = (os_cnt >= div - DIV_W'(1));
  assign bit_done = os_tick && (sub == SUB_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_cnt <= '0;
      sub    <= '0;
    end else if (restart) begin
      os_cnt <= '0;
      sub    <= '0;
    end else if (os_tick) begin
      os_cnt <= '0;
      sub    <= (sub == SUB_LAST) ? '0 : sub + 1'b1;
    end else begin
      os_cnt <= os_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_done,
  input  logic              have_data,
  input  logic [DATA_W-1:0] din,
  input  frame_cfg_t        cfg,
  input  logic              brk,
  output logic              pop,
  output logic              busy,
  output logic              tx_q
);
  localparam int FW = DATA_W + 4;
  localparam int IW = $clog2(FW);

  logic [FW-1:0] frame;
  logic [IW-1:0] idx, last;

  wire start_ok = have_data && !brk;
  wire at_end   = busy && bit_done && (idx == last);
  // a new frame may begin on the very edge the previous one ends
  assign pop = start_ok && (!busy || at_end);

  // slot after the data carries parity, or a stop bit when parity is off
  wire par_bit = cfg.par_en ? ^din : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame <= '1;
      idx   <= '0;
      last  <= '0;
      busy  <= 1'b0;
      tx_q  <= 1'b1;
    end else if (pop) begin
      frame <= {2'b11, par_bit, din, 1'b0};
      last  <= IW'(DATA_W + 1) + IW'(cfg.par_en) + IW'(cfg.two_stop);
      idx   <= '0;
      busy  <= 1'b1;
      tx_q  <= 1'b0;
    end else if (at_end) begin
      busy  <= 1'b0;
      tx_q  <= 1'b1;
    end else if (busy && bit_done) begin
      idx   <= idx + 1'b1;
      tx_q  <= frame[idx + 1'b1];
    end
  end

  // R2
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_q);
  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_q);
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit
  import sertx_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              par_en,
  input  logic              two_stop,
  input  logic              brk_en,
  input  logic              flush,
  output logic              tx_line,
  output logic              st_fifo_empty,
  output logic              st_fifo_full,
  output logic              st_fifo_half,
  output logic              st_tx_empty,
  output logic              st_tx_ready
);
  logic [DATA_W-1:0] q_dout;
  logic q_empty, q_full, q_half;
  logic pop, busy, tx_q, bit_done;
  frame_cfg_t cfg;

  assign cfg.par_en   = par_en;
  assign cfg.two_stop = two_stop;

  sertx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(wr_valid), .din(wr_data), .pop(pop),
    .dout(q_dout), .empty(q_empty), .full(q_full), .half(q_half)
  );

  sertx_baud #(.DIV_W(DIV_W), .OSR(SER_OSR)) u_baud (
    .clk(clk), .rst_n(rst_n), .restart(pop), .div(baud_div),
    .bit_done(bit_done)
  );

  sertx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_done(bit_done),
    .have_data(!q_empty && !flush), .din(q_dout), .cfg(cfg),
    .brk(brk_en), .pop(pop), .busy(busy), .tx_q(tx_q)
  );

  assign wr_ready      = !q_full && !flush;
  assign tx_line       = brk_en ? 1'b0 : tx_q;
  assign st_fifo_empty = q_empty;
  assign st_fifo_full  = q_full;
  assign st_fifo_half  = q_half;
  assign st_tx_empty   = q_empty && !busy;
  assign st_tx_ready   = !q_full;

  // R6
  brk_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(brk_en));
  // R10
  start_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(q_empty));
  // R10
  drained_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tx_empty && !brk_en) |-> tx_line);
endmodule

// File: tb/test_serial_tx_unit.sv
module test_serial_tx_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready;
  logic [9:0] baud_div = 10'd2;
  logic par_en = 1'b0, two_stop = 1'b0, brk_en = 1'b0, flush = 1'b0;
  logic tx_line, st_fifo_empty, st_fifo_full, st_fifo_half, st_tx_empty, st_tx_ready;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int last_fall = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_tx_unit i_serial_tx_unit (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .baud_div(baud_div), .par_en(par_en),
    .two_stop(two_stop), .brk_en(brk_en), .flush(flush), .tx_line(tx_line),
    .st_fifo_empty(st_fifo_empty), .st_fifo_full(st_fifo_full),
    .st_fifo_half(st_fifo_half), .st_tx_empty(st_tx_empty),
    .st_tx_ready(st_tx_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic at_cycle(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = b;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // decode one frame; p = clocks per bit
  task automatic rx_frame(input int p, input bit pe, input bit ts,
                          input logic [7:0] exp_b, input string tag);
    logic [7:0] d;
    int t0, n;
    do @(negedge clk); while (tx_line !== 1'b0);
    t0 = cyc;
    last_fall = t0;
    at_cycle(t0 + p / 2);
    chk(tx_line == 1'b0, "R2 start bit", tx_line, 0);
    for (int k = 0; k < 8; k++) begin
      at_cycle(t0 + (k + 1) * p + p / 2);
      d[k] = tx_line;
    end
    chk(d == exp_b, {"R2 data ", tag}, d, exp_b);
    n = 9;
    if (pe) begin
      at_cycle(t0 + n * p + p / 2);
      chk(tx_line == ^exp_b, "R4 parity bit", tx_line, ^exp_b);
      n++;
    end
    at_cycle(t0 + n * p + p / 2);
    chk(tx_line == 1'b1, "R5 stop bit 1", tx_line, 1);
    if (ts) begin
      n++;
      at_cycle(t0 + n * p + p / 2);
      chk(tx_line == 1'b1, "R5 stop bit 2", tx_line, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int divs[3] = '{2, 3, 5};
    int p, nb, t_a, cfg_i;
    logic [7:0] b0, b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_line == 1'b1, "R1 line idle", tx_line, 1);
    chk(st_fifo_empty == 1'b1, "R1 fifo empty", st_fifo_empty, 1);
    chk(st_tx_empty == 1'b1, "R1 tx empty", st_tx_empty, 1);
    chk(wr_ready == 1'b1 && st_tx_ready == 1'b1, "R1 ready", wr_ready, 1);
    chk(!st_fifo_full && !st_fifo_half, "R1 full/half low", st_fifo_full, 0);

    // R2 R3 R4 R5 R10 sweep over divisor, parity and stop count
    cfg_i = 0;
    foreach (divs[i]) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int ts = 0; ts < 2; ts++) begin
          baud_div = 10'(divs[i]);
          par_en   = pe[0];
          two_stop = ts[0];
          p  = 16 * divs[i];
          nb = 10 + pe + ts;
          b0 = 8'(8'h5A + cfg_i * 29);
          b1 = 8'(8'hC3 ^ (cfg_i * 53));
          fork
            begin push(b0); push(b1); end
            begin
              rx_frame(p, pe[0], ts[0], b0, "first");
              t_a = last_fall;
              rx_frame(p, pe[0], ts[0], b1, "second");
            end
          join
          chk(last_fall - t_a == nb * p, "R3 frame length", last_fall - t_a, nb * p);
          chk(st_tx_empty == 1'b0, "R10 busy in last stop", st_tx_empty, 0);
          chk(st_fifo_empty == 1'b1, "R10 queue drained", st_fifo_empty, 1);
          at_cycle(last_fall + nb * p);
          chk(st_tx_empty == 1'b1, "R10 empty after stop", st_tx_empty, 1);
          cfg_i++;
        end
      end
    end

    // R6 break holds line and stalls queue
    baud_div = 10'd2; par_en = 1'b0; two_stop = 1'b0;
    @(negedge clk);
    brk_en = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b0, "R6 break low", tx_line, 0);
    push(8'h3C);
    repeat (100) @(negedge clk);
    chk(tx_line == 1'b0, "R6 break held", tx_line, 0);
    chk(st_fifo_empty == 1'b0, "R6 byte kept queued", st_fifo_empty, 0);
    brk_en = 1'b0;
    rx_frame(32, 1'b0, 1'b0, 8'h3C, "after break");

    // R8 R9 fill under break, overflow attempt, ordered drain
    at_cycle(last_fall + 10 * 32 + 2);
    brk_en = 1'b1;
    for (int k = 0; k < 32; k++) begin
      push(8'(k * 7 + 1));
      if (k == 14) chk(st_fifo_half == 1'b0, "R9 half low at 15", st_fifo_half, 0);
      if (k == 15) chk(st_fifo_half == 1'b1, "R9 half high at 16", st_fifo_half, 1);
      if (k == 30) chk(st_fifo_full == 1'b0, "R8 not full at 31", st_fifo_full, 0);
    end
    chk(st_fifo_full == 1'b1, "R8 full at 32", st_fifo_full, 1);
    chk(wr_ready == 1'b0 && st_tx_ready == 1'b0, "R10 ready low when full", wr_ready, 0);
    push(8'hEE);
    chk(st_fifo_full == 1'b1, "R8 still full after drop", st_fifo_full, 1);
    brk_en = 1'b0;
    for (int k = 0; k < 32; k++) begin
      rx_frame(32, 1'b0, 1'b0, 8'(k * 7 + 1), "fill order");
      if (k == 0) chk(st_tx_ready == 1'b1, "R10 ready once room", st_tx_ready, 1);
    end
    at_cycle(last_fall + 10 * 32 + 3 * 32);
    chk(tx_line == 1'b1, "R8 dropped byte never sent", tx_line, 1);
    chk(st_tx_empty == 1'b1, "R8 drained after 32", st_tx_empty, 1);

    // R7 flush discards queued bytes
    brk_en = 1'b1;
    for (int k = 0; k < 5; k++) push(8'(8'h90 + k));
    chk(st_fifo_empty == 1'b0, "R7 queued before flush", st_fifo_empty, 0);
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(wr_ready == 1'b0, "R7 ready low in flush", wr_ready, 0);
    @(negedge clk);
    chk(st_fifo_empty == 1'b1, "R7 emptied", st_fifo_empty, 1);
    flush = 1'b0;
    brk_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      repeat (50) @(negedge clk);
      chk(tx_line == 1'b1, "R7 nothing sent", tx_line, 1);
    end
    chk(st_tx_empty == 1'b1, "R7 tx empty after flush", st_tx_empty, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule